// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Access Controller

This block sits between a simple host request port and a 16-bit pseudo-static RAM that is run in its asynchronous, SRAM-like mode. The host presents an address, a write word, a 2-bit byte enable and a read/write flag with a valid/ready handshake. The controller then sequences the active-low chip select, output enable, write strobe, upper and lower byte selects and the address-latch strobe. It holds the memory clock at 0 throughout.

All timing is counted in system clock cycles and set by parameters: read access time, address setup, total write pulse width, the longest allowed unbroken write-strobe low time, and data hold. When a write pulse is longer than the allowed maximum, it is cut into several low segments with one high cycle between them, and chip select stays asserted across the gaps. A read returns its data together with a single-cycle done pulse. A write also ends with a done pulse.

The memory's wait/ready indication carries no meaning in this mode, and the controller never looks at it.

Top module: `psram_async_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, and every active-low memory strobe (`mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_ub_n`, `mem_lb_n`, `mem_adv_n`) is 1.
- R2: A read with a nonzero byte enable drives `mem_ce_n` and `mem_oe_n` to 0 and keeps `mem_we_n` at 1. It drives `mem_ub_n` to `~req_be[1]` and `mem_lb_n` to `~req_be[0]`. `mem_addr` carries the request address.
- R3: A read samples the data bus only at the end of T_ACC strobe-active cycles. `done` is 1, with `rd_data` valid, in the cycle that follows the T_ACC-th clock edge after acceptance. On that same edge every strobe returns to 1.
- R4: Every read ends with one extra cycle in which `req_ready` is 0. This cycle coincides with the `done` pulse, so a following write cannot start its bus drive right after the read.
- R5: During a write, `mem_ce_n` and the selected byte strobes stay 0 and `mem_oe_n` stays 1 for the whole access. The write strobe only goes low after T_SU setup cycles.
- R6: The write strobe is low for T_WP cycles in total. No run of low cycles exceeds T_WMAX. Runs are separated by exactly one high cycle, so with the defaults the pulse is split into three runs of 2, 2 and 1 cycles.
- R7: During a write, the controller drives the write word onto `mem_dq`, unchanged, from the first fall of `mem_we_n` until `mem_ce_n` rises. That is T_HOLD cycles after the last rise of `mem_we_n`. During reads the controller never drives the bus.
- R8: A request with `req_be` = 2'b00 gives `done` = 1 in the cycle right after acceptance. No memory strobe goes low, and memory contents are unchanged.
- R9: With ADV_HOLD = 0, `mem_adv_n` is low for exactly the first cycle of each access. With ADV_HOLD = 1, it is low for every cycle that `mem_ce_n` is low.
- R10: `mem_clk` is 0 at all times.
- R11: The level of `mem_wait` has no effect on any output.
- R12: A write's `done` follows the edge that lies T_SU + T_WP + (number of gap cycles) + T_HOLD edges after acceptance. With the defaults that is 9 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| done | output | 1 | Single-cycle completion pulse |
| rd_data | output | 16 | Read word, valid with done after a read |
| mem_addr | output | AW | Memory address bus |
| mem_dq | inout | 16 | Memory data bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_adv_n | output | 1 | Address-latch strobe, active low |
| mem_clk | output | 1 | Memory clock, held at 0 |
| mem_wait | input | 1 | Memory wait indication, ignored |

## Verification
The bench builds two copies with the default timing: T_ACC = 4, T_SU = 1, T_WP = 5, T_WMAX = 2, T_HOLD = 1. One copy uses the pulsed address strobe and the other holds it low. Because T_WP exceeds T_WMAX, every write must split into runs of 2, 2 and 1 cycles, which exercises the segment and gap logic on each write. The behavioural memory model drives a garbage word until T_ACC cycles of output enable have passed, so a read that samples too early returns a visibly wrong value.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_TURN,
        ST_WSU,
        ST_WLOW,
        ST_WGAP,
        ST_WHOLD
    } psram_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic ub_n;
        logic lb_n;
        logic adv_n;
    } psram_strobes_t;

    localparam psram_strobes_t STROBES_IDLE = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

    // length of the next write-strobe run: what is left, capped at the limit
    function automatic int unsigned seg_len(int unsigned remain, int unsigned cap);
        return (remain > cap) ? cap : remain;
    endfunction

endpackage

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CW'(1));
endmodule

// File: rtl/psram_bus_io.sv
module psram_bus_io #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          drive,
    input  logic [DW-1:0] wdata,
    input  logic          capture,
    inout  wire  [DW-1:0] mem_dq,
    output logic [DW-1:0] rdata
);
    assign mem_dq = drive ? wdata : {DW{1'bz}};

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (capture)
            rdata <= mem_dq;
    end
endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
    import psram_pkg::*;
#(
    parameter int AW       = 21,
    parameter int T_ACC    = 4,
    parameter int T_SU     = 1,
    parameter int T_WP     = 5,
    parameter int T_WMAX   = 2,
    parameter int T_HOLD   = 1,
    parameter bit ADV_HOLD = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    input  logic [1:0]    req_be,
    output logic          done,
    output logic [15:0]   rd_data,
    output logic [AW-1:0] mem_addr,
    inout  wire  [15:0]   mem_dq,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_ub_n,
    output logic          mem_lb_n,
    output logic          mem_adv_n,
    output logic          mem_clk,
    input  logic          mem_wait
);
    localparam int DW = 16;
    localparam int CW = $clog2(T_ACC + T_SU + T_WP + T_HOLD + 2) + 1;

    psram_state_e   state;
    psram_strobes_t strb;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q;
    logic [CW-1:0]  remain;
    logic [CW-1:0]  seg;
    logic           drive;
    logic           done_q;
    logic           tmr_load;
    logic [CW-1:0]  tmr_val;
    logic           tmr_last;
    logic           accept;
    logic           go_mem;
    logic           wait_unused;

    assign wait_unused = mem_wait;
    assign req_ready   = (state == ST_IDLE);
    assign accept      = req_valid && req_ready;
    assign go_mem      = accept && (req_be != 2'b00);
    assign seg         = CW'(seg_len(int'(remain), T_WMAX));

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: if (go_mem) begin
                tmr_load = 1'b1;
                tmr_val  = req_write ? CW'(T_SU) : CW'(T_ACC);
            end
            ST_WSU, ST_WGAP: if (tmr_last) begin
                tmr_load = 1'b1;
                tmr_val  = seg;
            end
            ST_WLOW: if (tmr_last) begin
                tmr_load = 1'b1;
                tmr_val  = (remain != '0) ? CW'(1) : CW'(T_HOLD);
            end
            default: ;
        endcase
    end

    psram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    psram_bus_io #(.DW(DW)) u_bus (
        .clk     (clk),
        .rst     (rst),
        .drive   (drive),
        .wdata   (wdata_q),
        .capture (state == ST_RD && tmr_last),
        .mem_dq  (mem_dq),
        .rdata   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            strb    <= STROBES_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            remain  <= '0;
            drive   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!ADV_HOLD && state != ST_IDLE)
                strb.adv_n <= 1'b1;
            unique case (state)
                ST_IDLE: if (accept) begin
                    if (req_be == 2'b00) begin
                        done_q <= 1'b1;
                    end else begin
                        addr_q     <= req_addr;
                        wdata_q    <= req_wdata;
                        strb.ce_n  <= 1'b0;
                        strb.ub_n  <= ~req_be[1];
                        strb.lb_n  <= ~req_be[0];
                        strb.adv_n <= 1'b0;
                        if (req_write) begin
                            remain <= CW'(T_WP);
                            state  <= ST_WSU;
                        end else begin
                            strb.oe_n <= 1'b0;
                            state     <= ST_RD;
                        end
                    end
                end
                ST_RD: if (tmr_last) begin
                    strb   <= STROBES_IDLE;
                    done_q <= 1'b1;
                    state  <= ST_TURN;
                end
                ST_TURN: state <= ST_IDLE;
                ST_WSU, ST_WGAP: if (tmr_last) begin
                    strb.we_n <= 1'b0;
                    drive     <= 1'b1;
                    remain    <= remain - seg;
                    state     <= ST_WLOW;
                end
                ST_WLOW: if (tmr_last) begin
                    strb.we_n <= 1'b1;
                    state     <= (remain != '0) ? ST_WGAP : ST_WHOLD;
                end
                ST_WHOLD: if (tmr_last) begin
                    strb   <= STROBES_IDLE;
                    drive  <= 1'b0;
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done      = done_q;
    assign mem_addr  = addr_q;
    assign mem_ce_n  = strb.ce_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_we_n  = strb.we_n;
    assign mem_ub_n  = strb.ub_n;
    assign mem_lb_n  = strb.lb_n;
    assign mem_adv_n = strb.adv_n;
    assign mem_clk   = 1'b0;

    // checker state: length of the current write-strobe low run
    logic [CW-1:0] we_run;
    always_ff @(posedge clk) begin
        if (rst)
            we_run <= '0;
        else if (!mem_we_n)
            we_run <= we_run + 1'b1;
        else
            we_run <= '0;
    end

    assert_we_run_capped_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (we_run < CW'(T_WMAX)));

    assert_oe_off_in_write_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));

    assert_bus_released_R7: assert property (@(posedge clk) disable iff (rst)
        drive |-> mem_oe_n);

    assert_empty_no_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && req_be == 2'b00) |=> (mem_ce_n && done));

    assert_read_start_R2: assert property (@(posedge clk) disable iff (rst)
        (go_mem && !req_write) |=> (!mem_ce_n && !mem_oe_n && mem_we_n));

    assert_turn_after_read_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (!req_ready && done));
endmodule

// File: tb/psram_async_ctrl_tb.sv
module psram_model #(
    parameter int AW    = 21,
    parameter int T_ACC = 4
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    inout  wire  [15:0]   dq,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          ub_n,
    input  logic          lb_n
);
    logic [15:0] mem [0:63];
    int          acc_cnt;
    logic        prev_we;
    logic        rd_drv;

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        acc_cnt = 0;
        prev_we = 1'b1;
    end

    assign rd_drv = !ce_n && !oe_n && we_n;
    assign dq = rd_drv ? ((acc_cnt >= T_ACC) ? mem[addr[5:0]] : 16'hBAD0) : 16'hzzzz;

    always @(negedge clk) begin
        if (rd_drv) acc_cnt = acc_cnt + 1;
        else        acc_cnt = 0;
        if (!prev_we && we_n && !ce_n) begin
            if (!ub_n) mem[addr[5:0]][15:8] = dq[15:8];
            if (!lb_n) mem[addr[5:0]][7:0]  = dq[7:0];
        end
        prev_we = we_n;
    end
endmodule

module psram_async_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW     = 21;
    localparam int T_ACC  = 4;
    localparam int T_SU   = 1;
    localparam int T_WP   = 5;
    localparam int T_WMAX = 2;
    localparam int T_HOLD = 1;
    localparam int GAPS   = (T_WP + T_WMAX - 1) / T_WMAX - 1;
    localparam int SEGS   = GAPS + 1;
    localparam int WR_EDGES = T_SU + T_WP + GAPS + T_HOLD;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_be = 2'b00;
    logic          mem_wait = 1'b0;

    logic          req_ready, done;
    logic [15:0]   rd_data;
    logic [AW-1:0] mem_addr;
    wire  [15:0]   mem_dq;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_adv_n, mem_clk;

    logic          h_ready, h_done;
    logic [15:0]   h_rd_data;
    logic [AW-1:0] h_addr;
    wire  [15:0]   h_dq;
    logic h_ce_n, h_oe_n, h_we_n, h_ub_n, h_lb_n, h_adv_n, h_clk;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psram_async_ctrl #(.AW(AW), .T_ACC(T_ACC), .T_SU(T_SU), .T_WP(T_WP),
        .T_WMAX(T_WMAX), .T_HOLD(T_HOLD), .ADV_HOLD(1'b0)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_dq(mem_dq), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_adv_n(mem_adv_n), .mem_clk(mem_clk), .mem_wait(mem_wait));

    psram_model #(.AW(AW), .T_ACC(T_ACC)) u_mem (
        .clk(clk), .addr(mem_addr), .dq(mem_dq), .ce_n(mem_ce_n),
        .oe_n(mem_oe_n), .we_n(mem_we_n), .ub_n(mem_ub_n), .lb_n(mem_lb_n));

    psram_async_ctrl #(.AW(AW), .T_ACC(T_ACC), .T_SU(T_SU), .T_WP(T_WP),
        .T_WMAX(T_WMAX), .T_HOLD(T_HOLD), .ADV_HOLD(1'b1)) u_dut_hold (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(h_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .done(h_done), .rd_data(h_rd_data), .mem_addr(h_addr),
        .mem_dq(h_dq), .mem_ce_n(h_ce_n), .mem_oe_n(h_oe_n),
        .mem_we_n(h_we_n), .mem_ub_n(h_ub_n), .mem_lb_n(h_lb_n),
        .mem_adv_n(h_adv_n), .mem_clk(h_clk), .mem_wait(mem_wait));

    psram_model #(.AW(AW), .T_ACC(T_ACC)) u_mem_hold (
        .clk(clk), .addr(h_addr), .dq(h_dq), .ce_n(h_ce_n),
        .oe_n(h_oe_n), .we_n(h_we_n), .ub_n(h_ub_n), .lb_n(h_lb_n));

    // free-running bus monitors, sampled away from the active edge
    int   ce_low = 0, adv_low = 0, h_ce_low = 0, h_adv_low = 0;
    int   we_low = 0, we_falls = 0, we_run = 0, we_run_max = 0;
    int   oe_in_write = 0, clk_high = 0, dq_bad = 0;
    logic prev_we = 1'b1, in_wr = 1'b0;
    logic [15:0] exp_bus = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_ce_n)  ce_low++;
            if (!mem_adv_n) adv_low++;
            if (!h_ce_n)    h_ce_low++;
            if (!h_adv_n)   h_adv_low++;
            if (mem_clk || h_clk) clk_high++;
            if (!mem_we_n) begin
                we_low++;
                we_run++;
                if (we_run > we_run_max) we_run_max = we_run;
                if (prev_we) we_falls++;
                in_wr = 1'b1;
                if (!mem_oe_n) oe_in_write++;
            end else begin
                we_run = 0;
            end
            if (mem_ce_n) in_wr = 1'b0;
            if (in_wr && mem_dq !== exp_bus) dq_bad++;
            prev_we = mem_we_n;
        end
    end

    always @(negedge clk) mem_wait <= ~mem_wait;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // issue one request; returns negedges until done and ready seen with done
    task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] be, output int cyc, output logic rdy_at_done,
                          output logic [15:0] rdata);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        exp_bus   = d;
        @(posedge clk);
        cyc = 0;
        rdy_at_done = 1'b0;
        rdata = '0;
        while (cyc < 100) begin
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
            if (done) begin
                rdy_at_done = req_ready;
                rdata = rd_data;
                break;
            end
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_adv_n} == 6'h3f,
            "R1", "strobes after reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_adv_n}, 6'h3f);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
        int cyc; logic rdy; logic [15:0] rv;
        int c0 = ce_low, a0 = adv_low, hc0 = h_ce_low, ha0 = h_adv_low;
        int w0 = we_low, f0 = we_falls, b0 = dq_bad;
        do_req(1'b1, a, d, be, cyc, rdy, rv);
        chk(cyc == WR_EDGES + 1, "R12", "write done timing", cyc, WR_EDGES + 1);
        chk(we_low - w0 == T_WP, "R6", "total WE low", we_low - w0, T_WP);
        chk(we_falls - f0 == SEGS, "R6", "WE segments", we_falls - f0, SEGS);
        chk(we_run_max <= T_WMAX, "R6", "longest WE run", we_run_max, T_WMAX);
        chk(ce_low - c0 == WR_EDGES, "R5", "CE low through write", ce_low - c0, WR_EDGES);
        chk(oe_in_write == 0, "R5", "OE low during WE", oe_in_write, 0);
        chk(dq_bad - b0 == 0, "R7", "bus word during write", dq_bad - b0, 0);
        chk(adv_low - a0 == 1, "R9", "ADV pulse on write", adv_low - a0, 1);
        chk(h_adv_low - ha0 == h_ce_low - hc0, "R9", "ADV held on write",
            h_adv_low - ha0, h_ce_low - hc0);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [15:0] exp, input logic [1:0] be,
                          input string req);
        int cyc; logic rdy; logic [15:0] rv;
        int c0 = ce_low, a0 = adv_low, hc0 = h_ce_low, ha0 = h_adv_low;
        do_req(1'b0, a, 16'h0000, be, cyc, rdy, rv);
        chk(rv == exp, req, "read data", rv, exp);
        chk(cyc == T_ACC + 1, "R3", "read done timing", cyc, T_ACC + 1);
        chk(ce_low - c0 == T_ACC, "R2", "CE low cycles on read", ce_low - c0, T_ACC);
        chk(rdy == 1'b0, "R4", "ready during done of read", rdy, 0);
        chk(adv_low - a0 == 1, "R9", "ADV pulse on read", adv_low - a0, 1);
        chk(h_adv_low - ha0 == T_ACC, "R9", "ADV held on read", h_adv_low - ha0, T_ACC);
    endtask

    task automatic t_read_strobes();
        // sample mid-read: strobes for upper-only read
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 21'd7; req_be = 2'b10;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!mem_ce_n && !mem_oe_n && mem_we_n, "R2", "read strobe levels",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
        chk(!mem_ub_n && mem_lb_n, "R2", "byte selects for be=10",
            {mem_ub_n, mem_lb_n}, 2'b01);
        chk(mem_addr == 21'd7, "R2", "address on bus", mem_addr, 7);
        while (!done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_empty();
        int cyc; logic rdy; logic [15:0] rv;
        int c0 = ce_low;
        do_req(1'b1, 21'd3, 16'hFFFF, 2'b00, cyc, rdy, rv);
        chk(cyc == 1, "R8", "empty request done timing", cyc, 1);
        chk(ce_low - c0 == 0, "R8", "no strobe on empty request", ce_low - c0, 0);
        t_read(21'd3, 16'h1234, 2'b11, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write(21'd3, 16'h1234, 2'b11);
        t_read(21'd3, 16'h1234, 2'b11, "R3");
        t_write(21'd9, 16'hA5C3, 2'b11);
        t_write(21'd9, 16'h7E11, 2'b01);
        t_read(21'd9, 16'hA511, 2'b11, "R7");
        t_write(21'd9, 16'h4400, 2'b10);
        t_read(21'd9, 16'h4411, 2'b11, "R11");
        t_read_strobes();
        t_empty();
        chk(clk_high == 0, "R10", "memory clock high cycles", clk_high, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule